// File: doc/BRIEF.md
# Region Cacheability Attribute Table

This block keeps one attribute word for each of 256 equal 16 MB windows of a 32-bit address space. Two of its bits mean something: bit 0 lets the cache keep lines from the window, and bit 3 lets the prefetch logic read ahead in it. A cache or prefetch engine presents an address on the lookup port. In the same cycle it gets back the two flags for the window that the top eight address bits select.

Configuration software reads and writes the words through a simple indexed port. A word can be read in the same cycle, and a write lands on the next clock edge. The lowest sixteen windows cover on-core memory. Their words are fixed at cacheable, not prefetchable, and writes to them are dropped. Every other word starts at zero after reset. Reserved bits never hold state, so they always read as zero.

Top module: `region_attr_table`

## Requirements
- R1: The lookup port selects the attribute word by address bits 31:24 alone. Address bits 23:0 have no effect on the lookup outputs.
- R2: Bit 0 of an attribute word is the cacheable flag. It reads back as written and drives `lk_cacheable` for its window.
- R3: Bit 3 of an attribute word is the prefetchable flag. It reads back as written and feeds `lk_prefetchable` for its window.
- R4: All bits other than 0 and 3 read as zero whatever was written. A word written with only reserved bits set reads 0x0000_0000.
- R5: A write to index 0 to 15 has no effect. Those words always read 0x0000_0001.
- R6: A lookup whose address bits 31:24 are below 16 returns cacheable 1 and prefetchable 0.
- R7: After reset, every word from index 16 to 255 reads 0x0000_0000, and its window looks up as neither cacheable nor prefetchable.
- R8: A write on one clock edge is seen by the read port and by lookups from that edge on and not before. A word that is not written keeps its value.
- R9: `lk_prefetchable` is 0 whenever `lk_cacheable` is 0, even if the stored bit 3 is 1. The read port still returns the stored bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the attribute word at `cfg_idx` |
| cfg_idx | input | 8 | Attribute word index for both read and write |
| cfg_wdata | input | 32 | Write data; only bits 0 and 3 are kept |
| cfg_rdata | output | 32 | Current content of word `cfg_idx`, combinational |
| lk_addr | input | 32 | Address to classify |
| lk_cacheable | output | 1 | Window of `lk_addr` may be cached |
| lk_prefetchable | output | 1 | Window of `lk_addr` may be prefetched |

## Verification
A stored flag that has flipped or went to the wrong entry shows on the read port as soon as that index is selected. It shows on the lookup outputs in the first cycle an address from that window is presented, with no pipeline to hide it. A write decoder that hits the wrong entry, or hits a fixed entry, shows one cycle after the write when the affected index is read. Any leak of the reserved bits or loss of the prefetch gating shows at the ports in the same cycle. The bench model therefore compares both ports on every clock over a sweep, over directed writes and over a long random mix.

// File: rtl/rca_pkg.sv
`timescale 1ns/1ps
package rca_pkg;
   // Pair of implemented flags kept per region.
   typedef struct packed {
      logic cache;
      logic pref;
   } rca_flags_t;

   // Gate the prefetch permission by cacheability.
   function automatic rca_flags_t rca_gate(input rca_flags_t f);
      rca_flags_t o;
      o.cache = f.cache;
      o.pref  = f.cache & f.pref;
      return o;
   endfunction
endpackage

// File: rtl/rca_wdec.sv
`timescale 1ns/1ps
// One-hot write decoder covering only the writable index range.
module rca_wdec #(
   parameter int IDX_W = 8,
   parameter int FIRST = 16,
   parameter int NOUT  = 240
) (
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   output logic [NOUT-1:0]  hit
);
   generate
      for (genvar g = 0; g < NOUT; g++) begin : g_hit
         assign hit[g] = en && (idx == IDX_W'(g + FIRST));
      end
   endgenerate
endmodule

// File: rtl/rca_rw_entry.sv
`timescale 1ns/1ps
// Storage for one writable region: two flops, cleared by reset.
module rca_rw_entry (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic wcache,
   input  logic wpref,
   output logic cache,
   output logic pref
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cache <= 1'b0;
         pref  <= 1'b0;
      end else if (we) begin
         cache <= wcache;
         pref  <= wpref;
      end
   end
endmodule

// File: rtl/rca_pick.sv
`timescale 1ns/1ps
// Selects one region's flags from the flattened flag vectors.
module rca_pick #(
   parameter int IDX_W = 8,
   parameter int NREG  = 256
) (
   input  logic [NREG-1:0]  cache_v,
   input  logic [NREG-1:0]  pref_v,
   input  logic [IDX_W-1:0] idx,
   output rca_pkg::rca_flags_t flags
);
   always_comb begin
      flags.cache = cache_v[idx];
      flags.pref  = pref_v[idx];
   end
endmodule

// File: rtl/region_attr_table.sv
`timescale 1ns/1ps
module region_attr_table #(
   parameter int ADDR_W    = 32,
   parameter int REGION_W  = 8,
   parameter int DATA_W    = 32,
   parameter int RO_COUNT  = 16,
   parameter int CACHE_BIT = 0,
   parameter int PREF_BIT  = 3,
   parameter bit RO_CACHE  = 1'b1,
   parameter bit RO_PREF   = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [REGION_W-1:0] cfg_idx,
   input  logic [DATA_W-1:0]   cfg_wdata,
   output logic [DATA_W-1:0]   cfg_rdata,
   input  logic [ADDR_W-1:0]   lk_addr,
   output logic                lk_cacheable,
   output logic                lk_prefetchable
);
   import rca_pkg::*;

   localparam int NREG = 1 << REGION_W;
   localparam int NRW  = NREG - RO_COUNT;
   localparam int TOP  = ADDR_W - 1;

   // Elaboration-time parameter checks.
   generate
      if (REGION_W > ADDR_W) begin : g_bad_region
         $error("region index wider than address");
      end
      if (RO_COUNT < 0 || RO_COUNT >= NREG) begin : g_bad_ro
         $error("read-only count out of range");
      end
      if (CACHE_BIT == PREF_BIT) begin : g_bad_bits
         $error("flag bits must differ");
      end
      if (CACHE_BIT >= DATA_W || PREF_BIT >= DATA_W) begin : g_bad_width
         $error("flag bit beyond data width");
      end
   endgenerate

   logic [NREG-1:0] cache_v;
   logic [NREG-1:0] pref_v;
   logic [NRW-1:0]  wr_hit;

   rca_wdec #(
      .IDX_W (REGION_W),
      .FIRST (RO_COUNT),
      .NOUT  (NRW)
   ) u_wdec (
      .en  (cfg_we),
      .idx (cfg_idx),
      .hit (wr_hit)
   );

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         if (g < RO_COUNT) begin : g_ro
            assign cache_v[g] = RO_CACHE;
            assign pref_v[g]  = RO_PREF;
         end else begin : g_rw
            rca_rw_entry u_ent (
               .clk    (clk),
               .rst_n  (rst_n),
               .we     (wr_hit[g-RO_COUNT]),
               .wcache (cfg_wdata[CACHE_BIT]),
               .wpref  (cfg_wdata[PREF_BIT]),
               .cache  (cache_v[g]),
               .pref   (pref_v[g])
            );
         end
      end
   endgenerate

   // Reserved write bits intentionally dropped.
   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata;

   // Register read port.
   rca_flags_t rd_flags;
   rca_pick #(.IDX_W(REGION_W), .NREG(NREG)) u_rd_pick (
      .cache_v (cache_v),
      .pref_v  (pref_v),
      .idx     (cfg_idx),
      .flags   (rd_flags)
   );

   always_comb begin
      cfg_rdata            = '0;
      cfg_rdata[CACHE_BIT] = rd_flags.cache;
      cfg_rdata[PREF_BIT]  = rd_flags.pref;
   end

   // Lookup port: region from the top address bits.
   logic [REGION_W-1:0] lk_region;
   logic                unused_addr;
   assign lk_region   = lk_addr[TOP -: REGION_W];
   assign unused_addr = ^lk_addr;

   rca_flags_t lk_raw;
   rca_flags_t lk_out;
   rca_pick #(.IDX_W(REGION_W), .NREG(NREG)) u_lk_pick (
      .cache_v (cache_v),
      .pref_v  (pref_v),
      .idx     (lk_region),
      .flags   (lk_raw)
   );

   assign lk_out          = rca_gate(lk_raw);
   assign lk_cacheable    = lk_out.cache;
   assign lk_prefetchable = lk_out.pref;
endmodule

// File: rtl/rca_chk.sv
`timescale 1ns/1ps
module rca_chk #(
   parameter int ADDR_W    = 32,
   parameter int REGION_W  = 8,
   parameter int DATA_W    = 32,
   parameter int RO_COUNT  = 16,
   parameter int CACHE_BIT = 0,
   parameter int PREF_BIT  = 3,
   parameter bit RO_CACHE  = 1'b1,
   parameter bit RO_PREF   = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [REGION_W-1:0] cfg_idx,
   input logic [DATA_W-1:0]   cfg_wdata,
   input logic [DATA_W-1:0]   cfg_rdata,
   input logic [ADDR_W-1:0]   lk_addr,
   input logic                lk_cacheable,
   input logic                lk_prefetchable
);
   localparam logic [REGION_W-1:0] RO_LIM = REGION_W'(RO_COUNT);
   localparam logic [DATA_W-1:0] FLAG_MASK =
      (DATA_W'(1) << CACHE_BIT) | (DATA_W'(1) << PREF_BIT);
   localparam logic [DATA_W-1:0] RO_WORD =
      (DATA_W'(RO_CACHE) << CACHE_BIT) | (DATA_W'(RO_PREF) << PREF_BIT);

   logic [REGION_W-1:0] lk_region;
   logic                unused_chk;
   assign lk_region  = lk_addr[ADDR_W-1 -: REGION_W];
   assign unused_chk = ^lk_addr;

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~FLAG_MASK) == '0); // R4

   AST_RO_WORD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx < RO_LIM) |-> cfg_rdata == RO_WORD); // R5

   AST_RO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_region < RO_LIM) |-> (lk_cacheable == RO_CACHE &&
                                lk_prefetchable == (RO_CACHE & RO_PREF))); // R6

   AST_PREF_NEEDS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_prefetchable |-> lk_cacheable); // R9

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_we) && $past(cfg_idx) >= RO_LIM &&
       cfg_idx == $past(cfg_idx))
      |-> (cfg_rdata[CACHE_BIT] == $past(cfg_wdata[CACHE_BIT]) &&
           cfg_rdata[PREF_BIT]  == $past(cfg_wdata[PREF_BIT]))); // R8

   AST_UNWRITTEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cfg_we) && cfg_idx == $past(cfg_idx))
      |-> $stable(cfg_rdata)); // R8
endmodule

bind region_attr_table rca_chk #(
   .ADDR_W    (ADDR_W),
   .REGION_W  (REGION_W),
   .DATA_W    (DATA_W),
   .RO_COUNT  (RO_COUNT),
   .CACHE_BIT (CACHE_BIT),
   .PREF_BIT  (PREF_BIT),
   .RO_CACHE  (RO_CACHE),
   .RO_PREF   (RO_PREF)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_we          (cfg_we),
   .cfg_idx         (cfg_idx),
   .cfg_wdata       (cfg_wdata),
   .cfg_rdata       (cfg_rdata),
   .lk_addr         (lk_addr),
   .lk_cacheable    (lk_cacheable),
   .lk_prefetchable (lk_prefetchable)
);

// File: tb/region_attr_table_tb.sv
`timescale 1ns/1ps
module region_attr_table_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] lk_addr = '0;
   logic        lk_cacheable;
   logic        lk_prefetchable;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // Behavioural model: stored flags per writable region.
   bit ref_c [256];
   bit ref_p [256];

   always #4 clk = ~clk; // 125 MHz

   region_attr_table u_dut (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_idx (cfg_idx),
      .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .lk_addr (lk_addr),
      .lk_cacheable (lk_cacheable), .lk_prefetchable (lk_prefetchable)
   );

   task automatic check_ports(input string tag);
      int r;
      logic [31:0] exp_rd;
      logic exp_c, exp_p;
      // R5: fixed words read 1; R4: only bits 0 and 3 can be set.
      if (cfg_idx < 16) exp_rd = 32'h1;
      else exp_rd = {28'd0, ref_p[cfg_idx], 2'b00, ref_c[cfg_idx]};
      // R1: region from bits 31:24; R6 fixed windows; R9 gating.
      r = int'(lk_addr[31:24]);
      if (r < 16) begin exp_c = 1'b1; exp_p = 1'b0; end
      else begin exp_c = ref_c[r]; exp_p = ref_c[r] & ref_p[r]; end
      tests++;
      if (cfg_rdata !== exp_rd) begin
         fails++;
         $display("FAIL %s R4/R5 readback idx %0d: got %h exp %h", tag, cfg_idx, cfg_rdata, exp_rd);
      end
      tests++;
      if (lk_cacheable !== exp_c || lk_prefetchable !== exp_p) begin
         fails++;
         $display("FAIL %s R1/R6/R9 lookup %h: got c%b p%b exp c%b p%b",
                  tag, lk_addr, lk_cacheable, lk_prefetchable, exp_c, exp_p);
      end
   endtask

   task automatic step(input string tag, input bit we, input int idx,
                       input logic [31:0] wd, input logic [31:0] addr);
      @(negedge clk);
      cfg_we = we; cfg_idx = idx[7:0]; cfg_wdata = wd; lk_addr = addr;
      #2;
      check_ports(tag); // old contents before the edge (R8)
      @(posedge clk);
      if (we && idx >= 16) begin
         ref_c[idx] = wd[0];
         ref_p[idx] = wd[3];
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin ref_c[i] = 0; ref_p[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R7: reset contents, swept over every index and window.
      for (int i = 0; i < 256; i++)
         step("R7 reset sweep", 0, i, 0, {i[7:0], 24'h5A5A5A});

      // R5: writes to fixed words are dropped.
      for (int i = 0; i < 16; i++) step("R5 ro write", 1, i, 32'hFFFF_FFFF, {i[7:0], 24'h0});
      for (int i = 0; i < 16; i++) step("R5 ro read", 0, i, 0, {i[7:0], 24'hFFFFFF});

      // R4: reserved bits only; R2 and R3 flags; R8 visibility next cycle.
      step("R4 wr", 1, 20, 32'hFFFF_FFF6, 32'h1400_0000);
      step("R4 rd", 0, 20, 0, 32'h14FF_FFFF);
      step("R2 R3 wr", 1, 20, 32'h0000_0009, 32'h1400_0000);
      step("R8 rd", 0, 20, 0, 32'h1400_0000);
      step("R2 wr", 1, 255, 32'h0000_0001, 32'hFF00_0000);
      step("R2 rd", 0, 255, 0, 32'hFFFF_FFFF);
      // R9: prefetch stored but not cacheable.
      step("R9 wr", 1, 30, 32'h0000_0008, 32'h1E00_0000);
      step("R9 rd", 0, 30, 0, 32'h1E12_3456);
      // R1: window edges, low bits vary.
      step("R1 wr", 1, 200, 32'hFFFF_FFFF, 32'h0);
      step("R1 edge hi", 0, 16, 0, 32'hC8FF_FFFF);
      step("R1 edge lo", 0, 16, 0, 32'hC900_0000);
      step("R1 below", 0, 16, 0, 32'hC7FF_FFFF);
      step("R1 first rw", 1, 16, 32'h9, 32'h0FFF_FFFF);
      step("R1 first rw rd", 0, 16, 0, 32'h1000_0000);

      // Random mix of writes, reads and lookups.
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] w, a;
         int ix;
         w = $urandom; a = $urandom; ix = $urandom_range(0, 255);
         if (n % 3 == 0) a[31:24] = ix[7:0];
         step("R8 random", ($urandom_range(0, 2) == 0), ix, w, a);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule